// File: doc/BRIEF.md
# Page-Mode Nibble-Pair DRAM Fetch Controller

This controller sits between a byte-wide requester and a bank of four 64K x 1 dynamic RAM devices wired side by side. Each column access to that bank yields one 4-bit nibble. Every byte access runs in a fixed slot of eight cycles of a 16 MHz clock, numbered 0 to 7. In each slot the controller opens one row and then, in page mode, strobes two column addresses on the same shared 8-bit address bus while the row strobe stays low. On a read, the two nibbles are joined into one byte. On a write, the two nibbles of the write byte are driven out one after the other.

Requests use a valid/ready handshake. `req_ready` is high only in the last cycle of a slot, cycle 7, or in that same cycle while idle. A request that is held with `req_valid` is taken on the clock edge that opens cycle 0 of the next slot. While `req_ready` is low the requester must hold its request, and that is the only back-pressure. The read result is a plain one-cycle `rd_valid` pulse with no ready, because the slot timing is fixed and cannot be stalled. The byte address covers 32 KB. Bit 15 is ignored, bits 14:7 select the row and bits 6:0 select the column pair.

Top module: `nibdram_ctrl`

## Requirements
- R1: After reset, `ram_ras_n`, `ram_cas_n` and `ram_we_n` are high, `ram_dq_oe` and `rd_valid` are low, `rd_data` is 0 and `req_ready` is high in the first cycle.
- R2: `req_ready` is high only in cycle 7 of the repeating 8-cycle frame. A request is taken only when `req_valid` and `req_ready` are both high, and its slot starts in the next cycle as cycle 0.
- R3: During a slot, `ram_ras_n` is low in cycles 0 to 3 and high in cycles 4 to 7. When no slot is running, it stays high.
- R4: `ram_cas_n` is low in cycle 1 and in cycle 3 and high in every other cycle. This gives two falling edges under one row strobe.
- R5: `ram_a` carries the row `req_addr[14:7]` in cycle 0. It carries `{req_addr[6:0],1'b0}` in cycles 1 and 2, and `{req_addr[6:0],1'b1}` in cycle 3. `req_addr[15]` has no effect.
- R6: On a read, `ram_dq_in` is sampled on the clock edge that ends cycle 1 into `rd_data[3:0]`, and on the edge that ends cycle 3 into `rd_data[7:4]`. Values at any other edge are ignored.
- R7: `rd_valid` is high for exactly cycle 5 of a read slot and never during a write slot. `rd_data` holds the last read byte until the next read replaces it.
- R8: On a write, `ram_we_n` is low and `ram_dq_oe` is high in cycles 1 to 3. `ram_dq_out` carries `req_wdata[3:0]` in cycles 1 and 2 and `req_wdata[7:4]` in cycle 3. On a read, `ram_we_n` stays high and `ram_dq_oe` stays low.
- R9: A request taken in cycle 7 of a running slot starts its own slot in the very next cycle, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request is taken at this edge (cycle 7 only) |
| req_addr | input | 16 | Byte address, bit 15 ignored |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse, read byte available |
| rd_data | output | 8 | Assembled read byte, high nibble in 7:4 |
| ram_a | output | 8 | Multiplexed row/column address |
| ram_ras_n | output | 1 | Active-low row strobe |
| ram_cas_n | output | 1 | Active-low column strobe |
| ram_we_n | output | 1 | Active-low write enable |
| ram_dq_in | input | 4 | Nibble read from the RAM bank |
| ram_dq_out | output | 4 | Nibble driven to the RAM bank |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_out` |

## Verification
Two things happen in cycle 7 of a slot: the slot ends, and the next request is taken. The bench runs streams of back-to-back requests in which a new request is held valid during cycle 7 of the previous slot. It checks that the new row appears on `ram_a` with the row strobe low in the very next cycle. It also checks that the byte just read from the previous slot stays on `rd_data` unchanged while the next slot runs. Random garbage is driven on `ram_dq_in` at every edge except the two sampling edges, so that a capture at the wrong edge shows up in the assembled byte.

// File: rtl/nibdram_pkg.sv
package nibdram_pkg;
  localparam int SLOT_LEN = 8;
  localparam int PH_W     = $clog2(SLOT_LEN);
  localparam int NIB_W    = 4;
  localparam int BYTE_W   = 2 * NIB_W;
  localparam int RA_W     = 8;
  localparam int ADDR_W   = 16;
  localparam int COL_W    = RA_W - 1;

  localparam logic [PH_W-1:0] PH_ROW    = PH_W'(0);
  localparam logic [PH_W-1:0] PH_COL_LO = PH_W'(1);
  localparam logic [PH_W-1:0] PH_GAP    = PH_W'(2);
  localparam logic [PH_W-1:0] PH_COL_HI = PH_W'(3);
  localparam logic [PH_W-1:0] PH_VALID  = PH_W'(5);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(SLOT_LEN - 1);

  typedef struct packed {
    logic [RA_W-1:0]   row;
    logic [COL_W-1:0]  col;
    logic              wr;
    logic [BYTE_W-1:0] wdata;
  } slot_req_t;
endpackage

// File: rtl/slot_timer.sv
module slot_timer
  import nibdram_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  output logic            accept,
  output logic            active,
  output logic [PH_W-1:0] ph
);
  assign req_ready = (ph == PH_LAST);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_LAST;
      active <= 1'b0;
    end else begin
      ph <= (ph == PH_LAST) ? PH_ROW : ph + 1'b1;
      if (ph == PH_LAST) active <= req_valid;
    end
  end

  // R2
  slot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (active && ph == PH_ROW));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && ph != PH_LAST) |=> !active);
endmodule

// File: rtl/pin_sequencer.sv
module pin_sequencer
  import nibdram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [PH_W-1:0]   ph,
  input  slot_req_t         cur,
  output logic [RA_W-1:0]   ram_a,
  output logic              ram_ras_n,
  output logic              ram_cas_n,
  output logic              ram_we_n,
  output logic [NIB_W-1:0]  ram_dq_out,
  output logic              ram_dq_oe
);
  logic row_open, col_strobe, col_window, hi_sel, wr_drive;

  assign row_open   = active && (ph <= PH_COL_HI);
  assign col_strobe = active && (ph == PH_COL_LO || ph == PH_COL_HI);
  assign col_window = (ph == PH_COL_LO) || (ph == PH_GAP) || (ph == PH_COL_HI);
  assign hi_sel     = (ph == PH_COL_HI);
  assign wr_drive   = active && cur.wr && col_window;

  always_comb begin
    if (col_window) ram_a = {cur.col, hi_sel};
    else            ram_a = cur.row;
  end

  assign ram_ras_n  = !row_open;
  assign ram_cas_n  = !col_strobe;
  assign ram_we_n   = !wr_drive;
  assign ram_dq_oe  = wr_drive;
  assign ram_dq_out = hi_sel ? cur.wdata[BYTE_W-1:NIB_W] : cur.wdata[NIB_W-1:0];

  // R4
  cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cas_n |-> !ram_ras_n);

  // R4
  cas_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cas_n |=> ram_cas_n);

  // R8
  we_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_ras_n && ram_dq_oe));
endmodule

// File: rtl/nibble_gather.sv
module nibble_gather
  import nibdram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              is_wr,
  input  logic [PH_W-1:0]   ph,
  input  logic [NIB_W-1:0]  dq_in,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data
);
  logic rd_slot;
  assign rd_slot  = active && !is_wr;
  assign rd_valid = rd_slot && (ph == PH_VALID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_slot) begin
      if (ph == PH_COL_LO) rd_data[NIB_W-1:0]      <= dq_in;
      if (ph == PH_COL_HI) rd_data[BYTE_W-1:NIB_W] <= dq_in;
    end
  end

  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> $stable(rd_data));
endmodule

// File: rtl/nibdram_ctrl.sv
module nibdram_ctrl
  import nibdram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic [RA_W-1:0]   ram_a,
  output logic              ram_ras_n,
  output logic              ram_cas_n,
  output logic              ram_we_n,
  input  logic [NIB_W-1:0]  ram_dq_in,
  output logic [NIB_W-1:0]  ram_dq_out,
  output logic              ram_dq_oe
);
  logic            accept, active;
  logic [PH_W-1:0] ph;
  slot_req_t       cur;

  slot_timer u_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .active(active), .ph(ph)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (accept) begin
      cur.row   <= req_addr[2*RA_W-2:COL_W];
      cur.col   <= req_addr[COL_W-1:0];
      cur.wr    <= req_write;
      cur.wdata <= req_wdata;
    end
  end

  pin_sequencer u_pins (
    .clk(clk), .rst_n(rst_n), .active(active), .ph(ph), .cur(cur),
    .ram_a(ram_a), .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n),
    .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe)
  );

  nibble_gather u_gather (
    .clk(clk), .rst_n(rst_n), .active(active), .is_wr(cur.wr), .ph(ph),
    .dq_in(ram_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R3
  ras_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ram_ras_n);

  // R7
  no_rd_on_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ram_we_n);
endmodule

// File: tb/sim_nibdram_ctrl.sv
module sim_nibdram_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [15:0] req_addr = '0;
  logic       req_write = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [7:0] ram_a;
  logic       ram_ras_n, ram_cas_n, ram_we_n, ram_dq_oe;
  logic [3:0] ram_dq_in = '0;
  logic [3:0] ram_dq_out;

  int vectors = 0;
  int errors  = 0;
  logic [7:0] last_rd = 8'h00;

  always #4 clk = ~clk;

  nibdram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ram_a(ram_a),
    .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n), .ram_we_n(ram_we_n),
    .ram_dq_in(ram_dq_in), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe)
  );

  function automatic logic [3:0] mem_nib(input logic [7:0] row, input logic [7:0] col);
    logic [7:0] t;
    t = row * 8'd5 + col * 8'd3 + 8'd1;
    return t[3:0] ^ row[7:4];
  endfunction

  function automatic logic [7:0] exp_ra(input logic [15:0] a, input int k);
    if (k == 0) return a[14:7];
    if (k == 3) return {a[6:0], 1'b1};
    return {a[6:0], 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic idle_checks();
    chk("R3 idle ras", ram_ras_n, 1);
    chk("R4 idle cas", ram_cas_n, 1);
    chk("R8 idle we", ram_we_n, 1);
    chk("R8 idle oe", ram_dq_oe, 0);
    chk("R7 idle rd_valid", rd_valid, 0);
  endtask

  // Call at a negedge in cycle 7 (req_ready high); returns at negedge of next cycle 7.
  task automatic access(input logic [15:0] a, input logic wr, input logic [7:0] wd);
    logic [7:0] rd_exp;
    rd_exp = {mem_nib(a[14:7], {a[6:0], 1'b1}), mem_nib(a[14:7], {a[6:0], 1'b0})};
    chk("R2 ready in cycle 7", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        req_addr  = $urandom;
        req_wdata = $urandom;
        req_write = $urandom;
      end
      chk("R3 ras", ram_ras_n, (k <= 3) ? 1'b0 : 1'b1);
      chk("R4 cas", ram_cas_n, (k == 1 || k == 3) ? 1'b0 : 1'b1);
      if (k <= 3) chk("R5 addr", ram_a, exp_ra(a, k));
      chk("R2 ready", req_ready, (k == 7) ? 1'b1 : 1'b0);
      if (wr) begin
        chk("R8 we", ram_we_n, (k >= 1 && k <= 3) ? 1'b0 : 1'b1);
        chk("R8 oe", ram_dq_oe, (k >= 1 && k <= 3) ? 1'b1 : 1'b0);
        if (k == 1 || k == 2) chk("R8 low nibble", ram_dq_out, wd[3:0]);
        if (k == 3) chk("R8 high nibble", ram_dq_out, wd[7:4]);
        chk("R7 no valid on write", rd_valid, 0);
        chk("R7 rd_data held", rd_data, last_rd);
      end else begin
        chk("R8 read we", ram_we_n, 1);
        chk("R8 read oe", ram_dq_oe, 0);
        chk("R7 valid pulse", rd_valid, (k == 5) ? 1'b1 : 1'b0);
        if (k >= 4) chk("R6 assembled byte", rd_data, rd_exp);
        else if (k == 0) chk("R9 previous byte held", rd_data, last_rd);
      end
      if (k == 1) ram_dq_in = mem_nib(a[14:7], {a[6:0], 1'b0});
      else if (k == 3) ram_dq_in = mem_nib(a[14:7], {a[6:0], 1'b1});
      else ram_dq_in = $urandom;
    end
    if (!wr) last_rd = rd_exp;
  endtask

  task automatic idle_slot();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ram_dq_in = $urandom;
      idle_checks();
      chk("R2 idle ready", req_ready, (k == 7) ? 1'b1 : 1'b0);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, first cycle after reset
    idle_checks();
    chk("R1 rd_data reset", rd_data, 0);
    chk("R1 ready after reset", req_ready, 1);
    // R2 request not held: nothing starts
    idle_slot();
    // directed corners
    access(16'h0000, 1'b0, 8'h00);
    access(16'hFFFF, 1'b0, 8'h00);
    access(16'h7FFF, 1'b1, 8'hA5);  // R9 back-to-back read->write
    access(16'h807F, 1'b0, 8'h00);  // R5 bit 15 ignored
    idle_slot();
    access(16'h0080, 1'b1, 8'h3C);
    access(16'h1234, 1'b0, 8'h00);
    // random mix with occasional idle slots
    for (int i = 0; i < 300; i++) begin
      if (($urandom % 4) == 0) idle_slot();
      access(16'($urandom), 1'($urandom), 8'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule